// File: doc/BRIEF.md
# Reloadable Interval Timer

A down-counting interval timer whose period is set by software through a reload register. A small register port lets software load the reload value, start and stop the count, enable the interrupt, and read the overflow status, the interrupt flag and the live count. The count steps on a tick-enable input, so any upstream prescaler or clock-enable source sets the timebase. The width of the count is a parameter. A 12-bit instance serves as a general interval timer and a 32-bit instance serves as an event counter.

Software arms the timer by writing the reload value and then setting both enable bits in the control register. When the count reaches zero the timer raises its overflow status and, if interrupts are enabled, an interrupt flag that drives `irq_o`. An interrupt is acknowledged by writing zero to the control register and then writing the previous control value back, which restarts the count from the reload value.

Register map (3-bit address): 0 = control (bit 0 count enable, bit 1 interrupt enable), 1 = reload, 2 = status (bit 0 overflow), 3 = interrupt flag (bit 0), 4 = live count. All other bits read as zero, and addresses 5 to 7 read as zero. Writes to addresses 2 to 7 are ignored.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous reset the control, reload, status, interrupt-flag and count registers all read zero, and `irq_o` is low.
- R2: A write to address 1 stores the low CNT_W bits of `wr_data` as the reload value and discards the upper bits. The write changes neither the control register nor the live count.
- R3: A control write that sets bit 0 while count enable was 0 loads the count from the reload register at that clock edge.
- R4: While count enable is 1, each cycle with `tick_i` high and no control write steps the count. A nonzero count decrements by one. A count of zero is replaced by the reload value. When count enable is 0, ticks leave the count unchanged.
- R5: A step whose new count is zero sets status bit 0 (overflow). This means a reload value of zero gives an event on every tick.
- R6: The same step sets the interrupt flag only if control bit 1 is 1. `irq_o` equals the interrupt flag.
- R7: Writing 0 to the control register stops counting and clears both the overflow bit and the interrupt flag.
- R8: Writing the prior control value back after a clear restarts counting from the current reload value, with the interrupt flag low until the next terminal step.
- R9: In a cycle with a control write, the write takes precedence over `tick_i`. The count does not step in that cycle, and a write that keeps count enable at 1 leaves the count as it was.
- R10: Address 4 returns the live count, zero-extended, at any time. Reads are combinational on `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Interrupt request (interrupt flag) |

## Verification
The hardest situation to reach is a terminal step that coincides with software activity. Examples are a control write in the same cycle as a tick while the count sits at zero, or the clear-and-restore acknowledge sequence arriving just after the flag rises. Directed sequences place these writes on exact cycles with a tick held high. A long random phase then mixes small reload values, which make terminal steps frequent, with random control and reload writes. Throughout both phases a behavioural model is compared on every cycle.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_RELOAD = 3'd1,
        REG_STATUS = 3'd2,
        REG_FLAG   = 3'd3,
        REG_VALUE  = 3'd4
    } tmr_reg_e;

    typedef struct packed {
        logic irq_en;
        logic cnt_en;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t to_ctrl(input logic [1:0] bits);
        tmr_ctrl_t c;
        c.cnt_en = bits[0];
        c.irq_en = bits[1];
        return c;
    endfunction

    function automatic logic is_disarm(input tmr_ctrl_t c);
        return !c.cnt_en && !c.irq_en;
    endfunction

endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
    import interval_timer_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_low,
    input  logic             terminal_i,
    output tmr_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             ovf_o,
    output logic             flag_o,
    output logic             ctrl_wr_o,
    output logic             start_o
);
    tmr_reg_e  waddr;
    tmr_ctrl_t new_ctrl;
    logic      reload_wr;

    always_comb begin
        waddr     = tmr_reg_e'(wr_addr);
        new_ctrl  = to_ctrl(wr_low[1:0]);
        ctrl_wr_o = wr_en && (waddr == REG_CTRL);
        reload_wr = wr_en && (waddr == REG_RELOAD);
        start_o   = ctrl_wr_o && new_ctrl.cnt_en && !ctrl_o.cnt_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o   <= '0;
            reload_o <= '0;
            ovf_o    <= 1'b0;
            flag_o   <= 1'b0;
        end else begin
            if (ctrl_wr_o) begin
                ctrl_o <= new_ctrl;
                if (is_disarm(new_ctrl)) begin
                    ovf_o  <= 1'b0;
                    flag_o <= 1'b0;
                end
            end else if (terminal_i) begin
                ovf_o <= 1'b1;
                if (ctrl_o.irq_en) flag_o <= 1'b1;
            end
            if (reload_wr) reload_o <= wr_low;
        end
    end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             terminal_o
);
    logic             step;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        step       = run_i && tick_i && !hold_i;
        nxt        = (count_o == '0) ? reload_i : count_o - 1'b1;
        terminal_o = step && (nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)          count_o <= '0;
        else if (start_i) count_o <= reload_i;
        else if (step)    count_o <= nxt;
    end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import interval_timer_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic [2:0]        rd_addr,
    input  tmr_ctrl_t         ctrl_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              ovf_i,
    input  logic              flag_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        case (tmr_reg_e'(rd_addr))
            REG_CTRL:   rd_data[1:0]       = {ctrl_i.irq_en, ctrl_i.cnt_en};
            REG_RELOAD: rd_data[CNT_W-1:0] = reload_i;
            REG_STATUS: rd_data[0]         = ovf_i;
            REG_FLAG:   rd_data[0]         = flag_i;
            REG_VALUE:  rd_data[CNT_W-1:0] = count_i;
            default:    rd_data            = '0;
        endcase
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import interval_timer_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic             flag_q;
    logic             ctrl_wr;
    logic             start;
    logic             terminal;

    generate
        if (DATA_W > CNT_W) begin : g_pad
            logic unused_hi;
            assign unused_hi = ^wr_data[DATA_W-1:CNT_W];
        end
    endgenerate

    tmr_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_low(wr_data[CNT_W-1:0]), .terminal_i(terminal),
        .ctrl_o(ctrl_q), .reload_o(reload_q), .ovf_o(ovf_q),
        .flag_o(flag_q), .ctrl_wr_o(ctrl_wr), .start_o(start)
    );

    tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run_i(ctrl_q.cnt_en), .tick_i(tick_i),
        .hold_i(ctrl_wr), .start_i(start), .reload_i(reload_q),
        .count_o(count_q), .terminal_o(terminal)
    );

    tmr_read_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .rd_addr(rd_addr), .ctrl_i(ctrl_q), .reload_i(reload_q),
        .ovf_i(ovf_q), .flag_i(flag_q), .count_i(count_q), .rd_data(rd_data)
    );

    assign irq_o = flag_q;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             cen,
    input logic             ien,
    input logic             ctrl_wr,
    input logic [1:0]       wr_lo,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count,
    input logic             ovf
);
    p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_lo[0] && !cen) |=> (count == $past(reload)));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!cen && !ctrl_wr) |=> $stable(count));

    p_ovf_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> (count == '0));

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ien));

    p_disarm_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_lo == 2'b00) |=> (!irq && !ovf));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !(wr_lo[0] && !cen)) |=> $stable(count));
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .irq(irq_o), .cen(ctrl_q.cnt_en),
    .ien(ctrl_q.irq_en), .ctrl_wr(ctrl_wr), .wr_lo(wr_data[1:0]),
    .reload(reload_q), .count(count_q), .ovf(ovf_q)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_i = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [2:0]        rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int unsigned m_ctrl, m_rel, m_cnt, m_ovf, m_flg;
    localparam int unsigned MASK = (1 << CNT_W) - 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_interval_timer (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_rel = 0; m_cnt = 0; m_ovf = 0; m_flg = 0;
        end else if (wr_en && wr_addr == 3'd0) begin
            if (wr_data[0] && !m_ctrl[0]) m_cnt = m_rel;
            if (wr_data[1:0] == 2'b00) begin m_ovf = 0; m_flg = 0; end
            m_ctrl = int'(wr_data[1:0]);
        end else begin
            if (tick_i && m_ctrl[0]) begin
                m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
                if (m_cnt == 0) begin
                    m_ovf = 1;
                    if (m_ctrl[1]) m_flg = 1;
                end
            end
            if (wr_en && wr_addr == 3'd1) m_rel = wr_data & MASK;
        end
    end

    function automatic int unsigned model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_rel;
            3'd2: return m_ovf;
            3'd3: return m_flg;
            3'd4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R6 irq, R10 read path)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R6 irq_o vs model", irq_o, m_flg);
            check("R10 rd_data vs model", rd_data, model_rd(rd_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d, input bit tk = 0);
        @(posedge clk); #2;
        wr_en = 1; wr_addr = a; wr_data = d; tick_i = tk;
        @(posedge clk); #2;
        wr_en = 0; tick_i = 0;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #2;
        tick_i = 1;
        repeat (n) @(posedge clk);
        #2;
        tick_i = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input int unsigned exp, input string tag);
        @(posedge clk); #2;
        rd_addr = a;
        @(negedge clk);
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        for (int a = 0; a < 5; a++) rd_chk(a[2:0], 0, "R1 reset read");
        check("R1 irq after reset", irq_o, 0);
        // R2 reload write, width masking
        wr(3'd1, 32'hABCD_1005);
        rd_chk(3'd1, 32'h005, "R2 reload masked");
        rd_chk(3'd0, 0, "R2 ctrl untouched");
        rd_chk(3'd4, 0, "R2 count untouched");
        // R4 ticks ignored while disabled
        ticks(3);
        rd_chk(3'd4, 0, "R4 no step when disabled");
        // R3 arming loads count
        wr(3'd0, 32'h3);
        rd_chk(3'd4, 5, "R3 load on enable");
        ticks(4);
        rd_chk(3'd4, 1, "R4 decrement");
        rd_chk(3'd2, 0, "R5 no overflow yet");
        ticks(1);
        rd_chk(3'd4, 0, "R5 count at zero");
        rd_chk(3'd2, 1, "R5 overflow set");
        rd_chk(3'd3, 1, "R6 flag set");
        check("R6 irq high", irq_o, 1);
        ticks(1);
        rd_chk(3'd4, 5, "R4 reload at zero");
        // R2 reload write while running
        wr(3'd1, 32'h9);
        rd_chk(3'd0, 3, "R2 ctrl kept");
        rd_chk(3'd4, 5, "R2 count kept");
        // R7 acknowledge by clearing
        wr(3'd0, 32'h0);
        rd_chk(3'd2, 0, "R7 overflow cleared");
        rd_chk(3'd3, 0, "R7 flag cleared");
        check("R7 irq low", irq_o, 0);
        ticks(2);
        rd_chk(3'd4, 5, "R7 counting stopped");
        // R8 restore
        wr(3'd0, 32'h3);
        rd_chk(3'd4, 9, "R8 restart from reload");
        rd_chk(3'd3, 0, "R8 flag low after restore");
        ticks(9);
        check("R8 irq at next terminal", irq_o, 1);
        // R9 control write beats tick
        wr(3'd0, 32'h3, 1);
        rd_chk(3'd4, 0, "R9 no step on write cycle");
        // R6 without interrupt enable
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h1);
        rd_chk(3'd4, 9, "R3 load count-only arm");
        ticks(9);
        rd_chk(3'd2, 1, "R6 overflow without ien");
        rd_chk(3'd3, 0, "R6 flag stays low");
        check("R6 irq stays low", irq_o, 0);
        // R5 reload of zero
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h3);
        rd_chk(3'd2, 0, "R5 overflow clear before tick");
        ticks(1);
        rd_chk(3'd2, 1, "R5 zero reload event");
        check("R5 zero reload irq", irq_o, 1);
        // random phase, model compared every cycle
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #2;
            tick_i  = ($urandom % 2) == 0;
            rd_addr = 3'($urandom % 8);
            wr_en   = ($urandom % 8) == 0;
            wr_addr = 3'($urandom % 5);
            wr_data = (wr_addr == 3'd1) ? 32'($urandom % 6) : 32'($urandom);
        end
        @(posedge clk); #2;
        wr_en = 0; tick_i = 0;
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule